// File: doc/BRIEF.md
# Hint-Driven LLC Replacement Updater

This block holds the tag array and per-set recency order of a small set-associative last-level cache. Demand lookups hit or miss against the stored tags. A miss fills the least recently used way of its set and reports the line it displaced. A hit promotes the matching way to most recently used.

The core caches also send hit reports into the block. The core caches serve their own hits, so without these reports the last-level cache would see none of that reuse. A configuration input picks which core level the block listens to: first-level hits or second-level hits. A report from the selected level becomes a hint. A hint carries no data. When its tag is resident, it moves that line to the most recently used place, so lines that stay busy in the core caches are not chosen as victims.

A victim query port shows, combinationally, which way of any set would be replaced next. A free-running counter shows how many hints were accepted.

Top module: `llc_hint_lru`

## Requirements
- R1: After reset every line is invalid, the hint count is 0, no response is valid, and in every set way w holds recency rank w (rank 0 is most recent), so the victim of every set is way 3.
- R2: A demand miss writes the tag into the current LRU way of its set and makes that way most recent. One cycle later rsp_valid=1, rsp_hit=0 and rsp_way names that way. rsp_evict_valid=1 with rsp_evict_tag holding the old tag only if the replaced way was valid.
- R3: A demand hit leaves the tags unchanged and makes the hit way most recent. One cycle later rsp_valid=1, rsp_hit=1 and rsp_way names the hit way.
- R4: vq_way always shows the LRU way of set vq_set, with that way's tag on vq_tag and its valid bit on vq_valid, taken from the present state with no delay.
- R5: An accepted hint whose tag is resident in its set makes that way most recent. It changes no tag and produces no response (rsp_valid stays 0).
- R6: An accepted hint whose tag is not resident in its set leaves the recency order unchanged.
- R7: A hit event is accepted as a hint only when hit_evt_lvl equals cfg_hint_lvl (0 = first-level hit, 1 = second-level hit). Other events change neither the recency order nor the count.
- R8: hint_count rises by exactly 1 in the cycle after each accepted hint, whether or not the tag is resident, and wraps modulo 2^CNT_W.
- R9: When a demand access and an accepted hint name the same set in the same cycle, the demand update is applied first and the hint is matched against the result. A hint for the tag that the demand fill evicts is therefore dropped.
- R10: Demand accesses and hints change state only in the set they name.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dmd_valid | input | 1 | Demand lookup/fill request |
| dmd_set | input | IDX_W | Demand set index |
| dmd_tag | input | TAG_W | Demand tag |
| hit_evt_valid | input | 1 | Core-cache hit report |
| hit_evt_lvl | input | 1 | Level of the reported hit (0 first, 1 second) |
| hit_evt_set | input | IDX_W | Set index of the reported line |
| hit_evt_tag | input | TAG_W | Tag of the reported line |
| cfg_hint_lvl | input | 1 | Level whose hits become hints |
| vq_set | input | IDX_W | Victim query set |
| vq_way | output | WAY_W | LRU way of the queried set |
| vq_tag | output | TAG_W | Tag in that way |
| vq_valid | output | 1 | Valid bit of that way |
| rsp_valid | output | 1 | Demand response valid |
| rsp_hit | output | 1 | Demand hit |
| rsp_way | output | WAY_W | Way hit or filled |
| rsp_evict_valid | output | 1 | A valid line was displaced |
| rsp_evict_tag | output | TAG_W | Tag of the displaced line |
| hint_count | output | CNT_W | Accepted hint count |

## Verification
A corrupt recency rank shows up on the victim query port without delay. The victim way changes, or no way holds the oldest rank, so a sweep of vq_set exposes it in the same cycle. A wrong promotion after a hint or a demand access is not visible at the moment it happens. It shows only when a later miss in that set evicts a different tag than expected. For that reason each hint test reads the victim port right after the hint, and the ordering test reads the evicted tag of the miss it issues. A count error appears on hint_count one cycle after the event.

// File: rtl/lhu_pkg.sv
package lhu_pkg;
    typedef enum logic {
        LVL_FIRST  = 1'b0,
        LVL_SECOND = 1'b1
    } hit_lvl_e;
endpackage

// File: rtl/lhu_hint_filter.sv
module lhu_hint_filter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic             evt_lvl,
    input  logic             cfg_lvl,
    output logic             hint_ok,
    output logic [CNT_W-1:0] hint_cnt
);
    import lhu_pkg::*;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        hint_ok = evt_valid && (hit_lvl_e'(evt_lvl) == hit_lvl_e'(cfg_lvl));
        cnt_d   = cnt_q + (hint_ok ? CNT_W'(1) : CNT_W'(0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hint_cnt = cnt_q;

    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_lvl == cfg_lvl) |=> hint_cnt == $past(hint_cnt) + CNT_W'(1));
    a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_valid && evt_lvl == cfg_lvl) |=> $stable(hint_cnt));
endmodule

// File: rtl/lhu_tag_match.sv
module lhu_tag_match #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned TAG_W = 8,
    parameter int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [WAYS-1:0]            vld_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           way_o
);
    always_comb begin
        hit_o = 1'b0;
        way_o = '0;
        for (int w = 0; w < int'(WAYS); w++) begin
            if (vld_i[w] && tags_i[w] == tag_i) begin
                hit_o = 1'b1;
                way_o = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/lhu_lru_pick.sv
module lhu_lru_pick #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] ages_i,
    output logic [WAY_W-1:0]           way_o
);
    always_comb begin
        way_o = '0;
        for (int w = 0; w < int'(WAYS); w++) begin
            if (ages_i[w] == WAY_W'(WAYS - 1)) way_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/lhu_rank_promote.sv
module lhu_rank_promote #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic                       en_i,
    input  logic [WAY_W-1:0]           way_i,
    input  logic [WAYS-1:0][WAY_W-1:0] ages_i,
    output logic [WAYS-1:0][WAY_W-1:0] ages_o
);
    always_comb begin
        ages_o = ages_i;
        if (en_i) begin
            for (int w = 0; w < int'(WAYS); w++) begin
                if (WAY_W'(w) == way_i)           ages_o[w] = '0;
                else if (ages_i[w] < ages_i[way_i]) ages_o[w] = ages_i[w] + WAY_W'(1);
            end
        end
    end
endmodule

// File: rtl/llc_hint_lru.sv
module llc_hint_lru #(
    parameter int unsigned SETS  = 8,
    parameter int unsigned WAYS  = 4,
    parameter int unsigned TAG_W = 8,
    parameter int unsigned CNT_W = 8,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dmd_valid,
    input  logic [IDX_W-1:0] dmd_set,
    input  logic [TAG_W-1:0] dmd_tag,
    input  logic             hit_evt_valid,
    input  logic             hit_evt_lvl,
    input  logic [IDX_W-1:0] hit_evt_set,
    input  logic [TAG_W-1:0] hit_evt_tag,
    input  logic             cfg_hint_lvl,
    input  logic [IDX_W-1:0] vq_set,
    output logic [WAY_W-1:0] vq_way,
    output logic [TAG_W-1:0] vq_tag,
    output logic             vq_valid,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [WAY_W-1:0] rsp_way,
    output logic             rsp_evict_valid,
    output logic [TAG_W-1:0] rsp_evict_tag,
    output logic [CNT_W-1:0] hint_count
);
    typedef logic [WAYS-1:0][TAG_W-1:0] row_tag_t;
    typedef logic [WAYS-1:0][WAY_W-1:0] row_age_t;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tags;
        logic [SETS-1:0][WAYS-1:0]            vld;
        logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age;
        logic                                 rsp_valid;
        logic                                 rsp_hit;
        logic [WAY_W-1:0]                     rsp_way;
        logic                                 rsp_ev_valid;
        logic [TAG_W-1:0]                     rsp_ev_tag;
        logic [IDX_W-1:0]                     rsp_set;
    } st_t;

    st_t st_d, st_q, st_rst;

    logic             hint_ok;
    logic             d_hit, h_hit;
    logic [WAY_W-1:0] d_hway, d_vway, d_way, h_way;
    row_tag_t         d_tags, d_tags_new, h_tags;
    logic [WAYS-1:0]  d_vld, d_vld_new, h_vld;
    row_age_t         d_age, d_age_new, h_age, h_age_new, q_age;

    lhu_hint_filter #(.CNT_W(CNT_W)) i_filter (
        .clk(clk), .rst_n(rst_n), .evt_valid(hit_evt_valid), .evt_lvl(hit_evt_lvl),
        .cfg_lvl(cfg_hint_lvl), .hint_ok(hint_ok), .hint_cnt(hint_count)
    );

    // Demand path: lookup, victim choice, promotion of the touched way.
    always_comb begin
        d_tags = st_q.tags[dmd_set];
        d_vld  = st_q.vld[dmd_set];
        d_age  = st_q.age[dmd_set];
    end

    lhu_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_dmatch (
        .tags_i(d_tags), .vld_i(d_vld), .tag_i(dmd_tag), .hit_o(d_hit), .way_o(d_hway));
    lhu_lru_pick #(.WAYS(WAYS)) i_dpick (.ages_i(d_age), .way_o(d_vway));

    assign d_way = d_hit ? d_hway : d_vway;

    lhu_rank_promote #(.WAYS(WAYS)) i_dprom (
        .en_i(dmd_valid), .way_i(d_way), .ages_i(d_age), .ages_o(d_age_new));

    always_comb begin
        d_tags_new        = d_tags;
        d_vld_new         = d_vld;
        d_tags_new[d_way] = dmd_tag;
        d_vld_new[d_way]  = 1'b1;
    end

    // Hint path: sees the set after any same-cycle demand update.
    always_comb begin
        if (dmd_valid && hit_evt_set == dmd_set) begin
            h_tags = d_tags_new;
            h_vld  = d_vld_new;
            h_age  = d_age_new;
        end else begin
            h_tags = st_q.tags[hit_evt_set];
            h_vld  = st_q.vld[hit_evt_set];
            h_age  = st_q.age[hit_evt_set];
        end
    end

    lhu_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_hmatch (
        .tags_i(h_tags), .vld_i(h_vld), .tag_i(hit_evt_tag), .hit_o(h_hit), .way_o(h_way));
    lhu_rank_promote #(.WAYS(WAYS)) i_hprom (
        .en_i(hint_ok && h_hit), .way_i(h_way), .ages_i(h_age), .ages_o(h_age_new));

    // Victim query path.
    assign q_age = st_q.age[vq_set];
    lhu_lru_pick #(.WAYS(WAYS)) i_qpick (.ages_i(q_age), .way_o(vq_way));
    assign vq_tag   = st_q.tags[vq_set][vq_way];
    assign vq_valid = st_q.vld[vq_set][vq_way];

    always_comb begin
        st_rst = '0;
        for (int s = 0; s < int'(SETS); s++)
            for (int w = 0; w < int'(WAYS); w++)
                st_rst.age[s][w] = WAY_W'(w);
    end

    always_comb begin
        st_d = st_q;
        if (dmd_valid) begin
            st_d.tags[dmd_set] = d_tags_new;
            st_d.vld[dmd_set]  = d_vld_new;
            st_d.age[dmd_set]  = d_age_new;
        end
        if (hint_ok && h_hit) st_d.age[hit_evt_set] = h_age_new;
        st_d.rsp_valid    = dmd_valid;
        st_d.rsp_hit      = d_hit;
        st_d.rsp_way      = d_way;
        st_d.rsp_ev_valid = dmd_valid && !d_hit && d_vld[d_vway];
        st_d.rsp_ev_tag   = d_tags[d_vway];
        st_d.rsp_set      = dmd_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign rsp_valid       = st_q.rsp_valid;
    assign rsp_hit         = st_q.rsp_hit;
    assign rsp_way         = st_q.rsp_way;
    assign rsp_evict_valid = st_q.rsp_ev_valid;
    assign rsp_evict_tag   = st_q.rsp_ev_tag;

    // Every set must hold each rank exactly once.
    logic [SETS-1:0][WAYS-1:0] rank_seen;
    always_comb begin
        rank_seen = '0;
        for (int s = 0; s < int'(SETS); s++)
            for (int w = 0; w < int'(WAYS); w++)
                rank_seen[s][st_q.age[s][w]] = 1'b1;
    end

    for (genvar s = 0; s < int'(SETS); s++) begin : g_rank_chk
        a_r4_rank_unique: assert property (@(posedge clk) disable iff (!rst_n)
            rank_seen[s] == {WAYS{1'b1}});
    end

    a_r4_victim_is_lru: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.age[vq_set][vq_way] == WAY_W'(WAYS - 1));
    a_r2_fill_recent: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> st_q.age[st_q.rsp_set][rsp_way] <= WAY_W'(1));
    a_r3_hit_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> st_q.vld[st_q.rsp_set][rsp_way]);
    a_r2_evict_needs_miss: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_evict_valid |-> (rsp_valid && !rsp_hit));
endmodule

// File: tb/test_llc_hint_lru.sv
module test_llc_hint_lru;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dmd_valid = 1'b0;
    logic [2:0] dmd_set = '0;
    logic [7:0] dmd_tag = '0;
    logic       hit_evt_valid = 1'b0;
    logic       hit_evt_lvl = 1'b0;
    logic [2:0] hit_evt_set = '0;
    logic [7:0] hit_evt_tag = '0;
    logic       cfg_hint_lvl = 1'b0;
    logic [2:0] vq_set = '0;
    logic [1:0] vq_way;
    logic [7:0] vq_tag;
    logic       vq_valid;
    logic       rsp_valid, rsp_hit, rsp_evict_valid;
    logic [1:0] rsp_way;
    logic [7:0] rsp_evict_tag;
    logic [7:0] hint_count;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [7:0] exp_cnt = '0;

    always #5 clk = ~clk;

    llc_hint_lru i_llc_hint_lru (
        .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid), .dmd_set(dmd_set), .dmd_tag(dmd_tag),
        .hit_evt_valid(hit_evt_valid), .hit_evt_lvl(hit_evt_lvl), .hit_evt_set(hit_evt_set),
        .hit_evt_tag(hit_evt_tag), .cfg_hint_lvl(cfg_hint_lvl), .vq_set(vq_set),
        .vq_way(vq_way), .vq_tag(vq_tag), .vq_valid(vq_valid), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_evict_valid(rsp_evict_valid),
        .rsp_evict_tag(rsp_evict_tag), .hint_count(hint_count)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what, input int act, input int exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic victim(input string req, input int set, input int way, input int tag, input int vld);
        vq_set = 3'(set);
        #1;
        eq(req, "victim way", int'(vq_way), way);
        eq(req, "victim valid", int'(vq_valid), vld);
        if (vld != 0) eq(req, "victim tag", int'(vq_tag), tag);
    endtask

    task automatic demand(input string req, input int set, input int tag, input int hit,
                          input int way, input int evv, input int evt);
        @(negedge clk);
        dmd_valid = 1'b1; dmd_set = 3'(set); dmd_tag = 8'(tag);
        @(negedge clk);
        dmd_valid = 1'b0;
        eq(req, "rsp_valid", int'(rsp_valid), 1);
        eq(req, "rsp_hit", int'(rsp_hit), hit);
        eq(req, "rsp_way", int'(rsp_way), way);
        eq(req, "evict valid", int'(rsp_evict_valid), evv);
        if (evv != 0) eq(req, "evict tag", int'(rsp_evict_tag), evt);
    endtask

    task automatic hint(input string req, input int set, input int tag, input int lvl, input bit counted);
        @(negedge clk);
        hit_evt_valid = 1'b1; hit_evt_set = 3'(set); hit_evt_tag = 8'(tag); hit_evt_lvl = lvl[0];
        @(negedge clk);
        hit_evt_valid = 1'b0;
        if (counted) exp_cnt = exp_cnt + 8'd1;
        eq("R8", "hint_count", int'(hint_count), int'(exp_cnt));
        eq(req, "no response on hint", int'(rsp_valid), 0);
    endtask

    task automatic t_reset();
        eq("R1", "rsp_valid", int'(rsp_valid), 0);
        eq("R1", "hint_count", int'(hint_count), 0);
        victim("R1", 0, 3, 0, 0);
        victim("R1", 5, 3, 0, 0);
    endtask

    task automatic t_fill();
        demand("R2", 1, 'hA0, 0, 3, 0, 0);
        demand("R2", 1, 'hA1, 0, 2, 0, 0);
        demand("R2", 1, 'hA2, 0, 1, 0, 0);
        demand("R2", 1, 'hA3, 0, 0, 0, 0);
        victim("R4", 1, 3, 'hA0, 1);
    endtask

    task automatic t_hit();
        demand("R3", 1, 'hA0, 1, 3, 0, 0);
        victim("R3", 1, 2, 'hA1, 1);
    endtask

    task automatic t_evict();
        demand("R2", 1, 'hB0, 0, 2, 1, 'hA1);
        victim("R2", 1, 1, 'hA2, 1);
    endtask

    task automatic t_hint_promote();
        cfg_hint_lvl = 1'b0;
        hint("R5", 1, 'hA2, 0, 1'b1);
        victim("R5", 1, 0, 'hA3, 1);
    endtask

    task automatic t_hint_absent();
        hint("R6", 1, 'h55, 0, 1'b1);
        victim("R6", 1, 0, 'hA3, 1);
    endtask

    task automatic t_level_select();
        hint("R7", 1, 'hA3, 1, 1'b0);
        victim("R7", 1, 0, 'hA3, 1);
        cfg_hint_lvl = 1'b1;
        hint("R7", 1, 'hA3, 1, 1'b1);
        victim("R7", 1, 3, 'hA0, 1);
        hint("R7", 1, 'hA0, 0, 1'b0);
        victim("R7", 1, 3, 'hA0, 1);
    endtask

    task automatic t_same_cycle();
        // Order now A3,A2,B0,A0 (LRU). Fill C0 evicts A0 -> C0,A3,A2,B0.
        demand("R2", 1, 'hC0, 0, 3, 1, 'hA0);
        victim("R9", 1, 2, 'hB0, 1);
        // Miss D0 plus hint on B0 in one cycle: B0 is evicted first, hint dropped.
        @(negedge clk);
        dmd_valid = 1'b1; dmd_set = 3'd1; dmd_tag = 8'hD0;
        hit_evt_valid = 1'b1; hit_evt_set = 3'd1; hit_evt_tag = 8'hB0; hit_evt_lvl = 1'b1;
        @(negedge clk);
        dmd_valid = 1'b0; hit_evt_valid = 1'b0;
        exp_cnt = exp_cnt + 8'd1;
        eq("R9", "rsp_way", int'(rsp_way), 2);
        eq("R9", "evict tag", int'(rsp_evict_tag), 'hB0);
        eq("R8", "hint_count", int'(hint_count), int'(exp_cnt));
        victim("R9", 1, 1, 'hA2, 1);
    endtask

    task automatic t_isolation();
        victim("R10", 6, 3, 0, 0);
        victim("R10", 0, 3, 0, 0);
        demand("R10", 6, 'h11, 0, 3, 0, 0);
        victim("R10", 1, 1, 'hA2, 1);
        victim("R10", 6, 2, 0, 0);
    endtask

    task automatic t_count_wrap();
        @(negedge clk);
        hit_evt_valid = 1'b1; hit_evt_set = 3'd2; hit_evt_tag = 8'h77; hit_evt_lvl = 1'b1;
        repeat (256) @(negedge clk);
        hit_evt_valid = 1'b0;
        eq("R8", "hint_count after wrap", int'(hint_count), int'(exp_cnt));
        victim("R6", 2, 3, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_fill();
        t_hit();
        t_evict();
        t_hint_promote();
        t_hint_absent();
        t_level_select();
        t_same_cycle();
        t_isolation();
        t_count_wrap();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule